// File: doc/BRIEF.md
# Mode and Error Flag Register with Set/Clear Commands

This block holds the mode and error state of a serial port controller: an enable flag that selects run mode (set) or configuration mode (clear), a master-select flag, a mode-error flag and five error flags. The five error flags cover transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software never writes a flag value directly. Instead it issues a 16-bit command word in which each flag has one dedicated set bit and one dedicated clear bit. A single command can therefore change several flags, for example to clear every error at once.

The serial engine reports error events on a five-bit input. An event raises its flag only when the matching bit of the error-enable mask is on. That mask is the configuration word of this block, and writes to it are taken only in configuration mode. The engine's busy signal interlocks the change to configuration mode: a request to clear the enable flag while a transfer is in progress is held until busy falls. A single interrupt output is raised while any error flag is set.

Top module: `msr_status_reg`

## Requirements
- R1: After reset all flags, the deferred-clear state and the error-enable mask are 0, so `status_o` reads 0 apart from the busy bit, `ctrl_o` reads 0 and `err_irq_o` is low.
- R2: Command bit positions, from bit 0 to bit 15, are: clear enable, set enable, clear master, set master, clear RX-underflow, set RX-underflow, clear mode-error, set mode-error, clear TX-overflow, clear RX-overflow, clear abort, clear TX-underflow, set TX-overflow, set RX-overflow, set abort, set TX-underflow. A command sets or clears its flag, and the new value is visible in the cycle after the write edge.
- R3: When the set bit and the clear bit of the same flag are both 1 in one command, that flag keeps its value.
- R4: A single command can clear several flags; the value 0x0F50 clears all five error flags and the mode-error flag.
- R5: `status_o` bit positions: enable 0, master 1, TX-overflow 8, RX-overflow 9, abort 10, TX-underflow 11, RX-underflow 12, busy 13 (the live `busy_i` level), mode-error 14. All other bits read 0.
- R6: `err_evt_i` and the mask share one bit order: bit 0 TX-overflow, bit 1 RX-overflow, bit 2 abort, bit 3 TX-underflow, bit 4 RX-underflow. An event bit sets its flag on the next edge only if the matching mask bit is 1; otherwise it has no effect.
- R7: A hardware event that is enabled takes priority over a software clear of the same flag in the same cycle, so the flag ends up set.
- R8: A clear-enable command given while `busy_i` is high leaves the enable flag at 1. The flag falls at the first clock edge at which `busy_i` is low. A later set-enable command cancels the deferred clear.
- R9: `cfg_we` loads `cfg_data` into the error-enable mask only while the enable flag is 0; while it is 1 the write is ignored and `ctrl_o` keeps its value.
- R10: `err_irq_o` is the OR of the five error flags and the mode-error flag. It stays high until software clears those flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Set/clear command word |
| cfg_we | input | 1 | Error-enable mask write strobe |
| cfg_data | input | 5 | Error-enable mask value |
| busy_i | input | 1 | Transfer in progress from the serial engine |
| err_evt_i | input | 5 | Hardware error event pulses |
| status_o | output | 16 | Flag and busy status word |
| ctrl_o | output | 5 | Current error-enable mask |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The assertions check, on every cycle, four behaviours: the enable flag never drops while the engine is busy, the mask stays frozen in run mode, an error flag without its enable never rises on its own, and the interrupt tracks the error flags. They also check that a set-and-clear pair on the master flag changes nothing and that the clear-all value leaves every error flag at zero. The bench's scenarios cover the rest. It sweeps every flag against every set/clear pair from both start values. It sweeps every mask value against every event. It also runs the deferred clear and its cancellation across a busy window, and shows that an event wins over a software clear in the same cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int CMD_W  = 16;
    localparam int STAT_W = 16;
    localparam int NFLAG  = 8;
    localparam int NERR   = 5;
    localparam int ERR_BASE = NFLAG - NERR;
    localparam int BUSY_POS = 13;

    // flag indices inside the register
    localparam int FL_EN  = 0;
    localparam int FL_MS  = 1;
    localparam int FL_ME  = 2;
    localparam int FL_TE  = 3;
    localparam int FL_RE  = 4;
    localparam int FL_AE  = 5;
    localparam int FL_TUE = 6;
    localparam int FL_RUE = 7;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic             pend_clr;
        logic [NERR-1:0]  mask;
    } msr_state_t;

    function automatic int cmd_set_pos(input int idx);
        case (idx)
            FL_EN:   return 1;
            FL_MS:   return 3;
            FL_ME:   return 7;
            FL_TE:   return 12;
            FL_RE:   return 13;
            FL_AE:   return 14;
            FL_TUE:  return 15;
            default: return 5;
        endcase
    endfunction

    function automatic int cmd_clr_pos(input int idx);
        case (idx)
            FL_EN:   return 0;
            FL_MS:   return 2;
            FL_ME:   return 6;
            FL_TE:   return 8;
            FL_RE:   return 9;
            FL_AE:   return 10;
            FL_TUE:  return 11;
            default: return 4;
        endcase
    endfunction

    function automatic int stat_pos(input int idx);
        case (idx)
            FL_EN:   return 0;
            FL_MS:   return 1;
            FL_ME:   return 14;
            FL_TE:   return 8;
            FL_RE:   return 9;
            FL_AE:   return 10;
            FL_TUE:  return 11;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/msr_cmd_decode.sv
module msr_cmd_decode
    import msr_pkg::*;
(
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_data,
    output logic [NFLAG-1:0] set_v,
    output logic [NFLAG-1:0] clr_v
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_dec
        localparam int SP = cmd_set_pos(i);
        localparam int CP = cmd_clr_pos(i);
        assign set_v[i] = cmd_we & cmd_data[SP];
        assign clr_v[i] = cmd_we & cmd_data[CP];
    end
endmodule

// File: rtl/msr_flag_next.sv
module msr_flag_next (
    input  logic cur,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    output logic nxt
);
    logic set_only;
    logic clr_only;

    always_comb begin
        set_only = sw_set & ~sw_clr;
        clr_only = sw_clr & ~sw_set;
        // hardware event beats a software clear in the same cycle
        nxt = set_only | hw_set | (cur & ~clr_only);
    end
endmodule

// File: rtl/msr_mode_interlock.sv
module msr_mode_interlock (
    input  logic en_q,
    input  logic pend_q,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic busy,
    output logic en_d,
    output logic pend_d
);
    logic set_only;
    logic clr_only;

    always_comb begin
        set_only = sw_set & ~sw_clr;
        clr_only = sw_clr & ~sw_set;
        en_d     = en_q;
        pend_d   = pend_q;
        if (set_only) begin
            en_d   = 1'b1;
            pend_d = 1'b0;
        end else if (clr_only) begin
            if (busy) begin
                pend_d = 1'b1;
            end else begin
                en_d   = 1'b0;
                pend_d = 1'b0;
            end
        end else if (pend_q && !busy) begin
            en_d   = 1'b0;
            pend_d = 1'b0;
        end
    end
endmodule

// File: rtl/msr_status_reg.sv
module msr_status_reg
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              cfg_we,
    input  logic [NERR-1:0]   cfg_data,
    input  logic              busy_i,
    input  logic [NERR-1:0]   err_evt_i,
    output logic [STAT_W-1:0] status_o,
    output logic [NERR-1:0]   ctrl_o,
    output logic              err_irq_o
);
    msr_state_t st_d, st_q;

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] hw_v;
    logic [NFLAG-1:0] flag_nxt;
    logic             pend_nxt;

    msr_cmd_decode u_dec (
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .set_v    (set_v),
        .clr_v    (clr_v)
    );

    // hardware events reach only the error flags, each gated by its mask bit
    for (genvar i = 0; i < NFLAG; i++) begin : g_hw
        if (i >= ERR_BASE) begin : g_err
            assign hw_v[i] = err_evt_i[i-ERR_BASE] & st_q.mask[i-ERR_BASE];
        end else begin : g_none
            assign hw_v[i] = 1'b0;
        end
    end

    msr_mode_interlock u_mode (
        .en_q   (st_q.flags[FL_EN]),
        .pend_q (st_q.pend_clr),
        .sw_set (set_v[FL_EN]),
        .sw_clr (clr_v[FL_EN]),
        .busy   (busy_i),
        .en_d   (flag_nxt[FL_EN]),
        .pend_d (pend_nxt)
    );

    for (genvar i = 1; i < NFLAG; i++) begin : g_flag
        msr_flag_next u_fn (
            .cur    (st_q.flags[i]),
            .sw_set (set_v[i]),
            .sw_clr (clr_v[i]),
            .hw_set (hw_v[i]),
            .nxt    (flag_nxt[i])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.flags    = flag_nxt;
        st_d.pend_clr = pend_nxt;
        if (cfg_we && !st_q.flags[FL_EN]) begin
            st_d.mask = cfg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o = '0;
        for (int i = 0; i < NFLAG; i++) begin
            status_o[stat_pos(i)] = st_q.flags[i];
        end
        status_o[BUSY_POS] = busy_i;
    end

    assign ctrl_o    = st_q.mask;
    assign err_irq_o = |st_q.flags[NFLAG-1:FL_ME];

endmodule

// File: rtl/msr_status_chk.sv
module msr_status_chk
    import msr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              busy_i,
    input logic [NERR-1:0]   err_evt_i,
    input logic [STAT_W-1:0] status_o,
    input logic [NERR-1:0]   ctrl_o,
    input logic              err_irq_o
);
    // R8
    p_busy_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && busy_i) |=> status_o[0]);

    // R9
    p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |=> $stable(ctrl_o));

    // R6
    p_gated_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[0] && !status_o[8] && !(cmd_we && cmd_data[12])) |=> !status_o[8]);

    // R3
    p_pair_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[2] && cmd_data[3]) |=> $stable(status_o[1]));

    // R4
    p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data == 16'h0F50 && err_evt_i == '0)
        |=> (status_o[12:8] == 5'd0 && !status_o[14]));

    // R10
    p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o == (|status_o[12:8] || status_o[14]));
endmodule

bind msr_status_reg msr_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_data  (cmd_data),
    .busy_i    (busy_i),
    .err_evt_i (err_evt_i),
    .status_o  (status_o),
    .ctrl_o    (ctrl_o),
    .err_irq_o (err_irq_o)
);

// File: tb/sim_msr_status_reg.sv
module sim_msr_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_data = '0;
    logic        busy_i = 1'b0;
    logic [4:0]  err_evt_i = '0;
    logic [15:0] status_o;
    logic [4:0]  ctrl_o;
    logic        err_irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msr_status_reg u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .cfg_we(cfg_we), .cfg_data(cfg_data), .busy_i(busy_i),
        .err_evt_i(err_evt_i), .status_o(status_o), .ctrl_o(ctrl_o),
        .err_irq_o(err_irq_o)
    );

    // flag order: en, ms, me, te, re, ae, tue, rue
    function automatic int t_set(input int i);
        int tbl[8] = '{1, 3, 7, 12, 13, 14, 15, 5};
        return tbl[i];
    endfunction
    function automatic int t_clr(input int i);
        int tbl[8] = '{0, 2, 6, 8, 9, 10, 11, 4};
        return tbl[i];
    endfunction
    function automatic int t_stat(input int i);
        int tbl[8] = '{0, 1, 14, 8, 9, 10, 11, 12};
        return tbl[i];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [15:0] v);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_data = v;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_data = '0;
    endtask

    task automatic do_cfg(input logic [4:0] m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_data = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", {16'd0, status_o}, 32'd0);
        check("R1 ctrl", {27'd0, ctrl_o}, 32'd0);
        check("R1 irq", {31'd0, err_irq_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after release", {16'd0, status_o}, 32'd0);

        // R5 busy reflected at bit 13
        busy_i = 1'b1;
        #1;
        check("R5 busy bit", {16'd0, status_o}, 32'h2000);
        busy_i = 1'b0;

        // R2 R3 R5 R10: every flag x every set/clear pair x both start values
        for (int i = 0; i < 8; i++) begin
            for (int init = 0; init < 2; init++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [15:0] cw;
                    logic        s, k, e;
                    logic [15:0] exp_st;
                    do_cmd(16'h0F55);
                    if (init == 1) do_cmd(16'(1) << t_set(i));
                    s = c[0];
                    k = c[1];
                    cw = '0;
                    if (s) cw[t_set(i)] = 1'b1;
                    if (k) cw[t_clr(i)] = 1'b1;
                    do_cmd(cw);
                    e = (s && !k) ? 1'b1 : ((k && !s) ? 1'b0 : init[0]);
                    exp_st = '0;
                    exp_st[t_stat(i)] = e;
                    if (s && k) check("R3 pair keeps flag", {16'd0, status_o}, {16'd0, exp_st});
                    else        check("R2 set/clear bit", {16'd0, status_o}, {16'd0, exp_st});
                    check("R10 irq follows errors", {31'd0, err_irq_o}, {31'd0, (i >= 2) && e});
                end
            end
        end

        // R4 set all errors and mode-error, clear with one write
        do_cmd(16'h0F55);
        do_cmd(16'hF0A0);
        check("R4 all set", {16'd0, status_o}, 32'h5F00);
        repeat (3) @(negedge clk);
        check("R10 irq sticky", {31'd0, err_irq_o}, 32'd1);
        do_cmd(16'h0F50);
        check("R4 clear all", {16'd0, status_o}, 32'd0);
        check("R10 irq cleared", {31'd0, err_irq_o}, 32'd0);

        // R6 every mask against every event
        for (int m = 0; m < 32; m++) begin
            do_cfg(5'(m));
            check("R6 mask loaded", {27'd0, ctrl_o}, m);
            for (int k = 0; k < 5; k++) begin
                do_cmd(16'h0F50);
                @(negedge clk);
                err_evt_i = 5'(1) << k;
                @(negedge clk);
                err_evt_i = '0;
                check("R6 gated event", {16'd0, status_o},
                      ((m >> k) & 1) ? (32'h100 << k) : 32'd0);
            end
        end

        // R7 enabled event beats clear in same cycle
        do_cfg(5'h1F);
        do_cmd(16'h1000);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_data = 16'h0100;
        err_evt_i = 5'b00001;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_data = '0;
        err_evt_i = '0;
        check("R7 event wins", {31'd0, status_o[8]}, 32'd1);
        do_cmd(16'h0F50);

        // R9 config ignored in run mode
        do_cfg(5'h0A);
        do_cmd(16'h0002);
        do_cfg(5'h15);
        check("R9 ignored in run mode", {27'd0, ctrl_o}, 32'h0A);
        check("R9 run flag", {31'd0, status_o[0]}, 32'd1);

        // R8 deferred clear
        @(negedge clk);
        busy_i = 1'b1;
        cmd_we = 1'b1;
        cmd_data = 16'h0001;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_data = '0;
        check("R8 held while busy", {31'd0, status_o[0]}, 32'd1);
        repeat (3) @(negedge clk);
        check("R8 still held", {31'd0, status_o[0]}, 32'd1);
        busy_i = 1'b0;
        @(negedge clk);
        check("R8 drops after busy", {31'd0, status_o[0]}, 32'd0);
        do_cfg(5'h15);
        check("R9 accepted in config mode", {27'd0, ctrl_o}, 32'h15);

        // R8 cancel by set-enable
        do_cmd(16'h0002);
        @(negedge clk);
        busy_i = 1'b1;
        cmd_we = 1'b1;
        cmd_data = 16'h0001;
        @(negedge clk);
        cmd_data = 16'h0002;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_data = '0;
        busy_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 cancel keeps run", {31'd0, status_o[0]}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule